// File: doc/BRIEF.md
# Addressable Bit Register with Decode Mode

This block is an eight-cell bit register. Each cell can be written on its own through a 3-bit address and a single data line. Two active-low control pins pick one of four modes for every clock cycle: write one addressed cell, hold all cells, decode (the addressed output takes the data value and every other output goes low), or clear all cells. All updates are registered on the rising edge of `clk`, and a separate asynchronous power-on reset clears the register at any time.

Typical uses are serial-to-parallel loading, where one bit is placed per write cycle, and a 1-of-8 active-high select generator, which is decode mode with the data line held high. There is no data stream through the block, so every pin is a plain level with no valid/ready handshake. There is no back-pressure: every cycle's controls take effect on the next rising edge. The caller must keep the address stable across consecutive write cycles, or change it by at most one bit. Larger address moves belong in a hold cycle.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low, `q` is all zeros, whatever the other inputs do.
- R2: In write mode (`le_n`=0, `mr_n`=1), the cell selected by `addr` holds the value of `d` after the rising edge.
- R3: In write mode, the seven cells not selected by `addr` keep their previous values across the edge.
- R4: In hold mode (`le_n`=1, `mr_n`=1), `q` does not change, whatever `addr` and `d` do.
- R5: In decode mode (`le_n`=0, `mr_n`=0), after the edge the selected output equals `d` and every other output is 0.
- R6: In decode mode with `d`=1, exactly one bit of `q` is set after the edge, so the block acts as a 3-to-8 one-hot decoder.
- R7: In clear mode (`le_n`=1, `mr_n`=0), `q` becomes all zeros after the edge, whatever `addr` and `d` are.
- R8: `addr` is unsigned with `addr[0]` as its least significant bit, and address value k selects `q[k]`.
- R9: After decode or clear mode, entering hold mode keeps the last values driven onto `q`.
- R10: Across two consecutive write cycles, `addr` changes in at most one bit. This is a rule for the caller and is checked on the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock that samples all controls |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| addr | input | 3 | Cell select, bit 0 least significant |
| d | input | 1 | Data value for the selected cell |
| le_n | input | 1 | Active-low write enable |
| mr_n | input | 1 | Active-low common clear |
| q | output | 8 | Stored cell values, active high |

## Verification
The bench writes all eight addresses with alternating data. A design with the address bits reversed, or one that disturbs neighbouring cells on a write, then shows a wrong pattern in `q`. Hold cycles toggle `addr` and `d` freely, which exposes a design that lets hold fall through to a write. Decode mode is run with `d` high and with `d` low on a register that is already full. A design that merges the decode pattern into the old contents, instead of forcing the other cells low, leaves stray ones. Clear mode with nonzero `addr` and `d`, a hold after both decode and clear, and a reset asserted in the middle of a run round out the corners.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR = 2'd3
  } alatch_mode_e;
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic         le_n,
  input  logic         mr_n,
  output alatch_mode_e mode
);
  always_comb begin
    unique case ({mr_n, le_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DECODE;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alatch_sel_dec.sv
module alatch_sel_dec #(
  parameter int ADDR_W = 3,
  localparam int NCELL = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCELL-1:0]  sel
);
  for (genvar i = 0; i < NCELL; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/alatch_cell_bank.sv
module alatch_cell_bank
  import addr_latch_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  alatch_mode_e     mode,
  input  logic [NCELL-1:0] sel,
  input  logic             d,
  output logic [NCELL-1:0] q
);
  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic nxt;
    always_comb begin
      unique case (mode)
        MODE_WRITE:  nxt = sel[i] ? d : q[i];
        MODE_HOLD:   nxt = q[i];
        MODE_DECODE: nxt = sel[i] & d;
        default:     nxt = 1'b0;
      endcase
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt;
    end
  end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NCELL = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              d,
  input  logic              le_n,
  input  logic              mr_n,
  output logic [NCELL-1:0]  q
);
  alatch_mode_e     mode;
  logic [NCELL-1:0] sel;

  alatch_mode_dec u_mode (.le_n(le_n), .mr_n(mr_n), .mode(mode));
  alatch_sel_dec #(.ADDR_W(ADDR_W)) u_sel (.addr(addr), .sel(sel));
  alatch_cell_bank #(.NCELL(NCELL)) u_bank (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .d(d), .q(q)
  );

  // one clock of history since reset release
  logic hist_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_ok <= 1'b0;
    else        hist_ok <= 1'b1;
  end

  wire wr_now  = !le_n && mr_n;
  wire hold_now = le_n && mr_n;
  wire dec_now = !le_n && !mr_n;
  wire clr_now = le_n && !mr_n;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> q == '0);
  p_write_bit_r2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> q[$past(addr)] == $past(d));
  p_write_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> (q & ~$past(sel)) == ($past(q) & ~$past(sel)));
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> $stable(q));
  p_decode_others_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_now |=> ((q & ~$past(sel)) == '0) && (q[$past(addr)] == $past(d)));
  p_decode_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_now && d) |=> $countones(q) == 1);
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> q == '0);
  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && wr_now && $past(wr_now)) |-> $countones(addr ^ $past(addr)) <= 1);
endmodule

// File: tb/sim_addr_latch8.sv
module sim_addr_latch8;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    addr = '0;
  logic          d = 1'b0;
  logic          le_n = 1'b1;
  logic          mr_n = 1'b1;
  logic [NB-1:0] q;

  addr_latch8 u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .d(d),
                  .le_n(le_n), .mr_n(mr_n), .q(q));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NB-1:0] exp_q[$];
  string         tag_q[$];
  logic [NB-1:0] model = '0;
  int            errors = 0;
  int            checks = 0;
  bit            done = 1'b0;

  // monitor: compare one expected item per cycle, away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [NB-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (q !== e) begin
        errors++;
        $display("FAIL %s: q=%b expected %b", t, q, e);
      end
    end
  end

  // driver: apply one cycle and push the expected result
  task automatic cyc(input logic le, input logic mr, input logic [2:0] a,
                     input logic dv, input string tag);
    @(negedge clk);
    le_n = le; mr_n = mr; addr = a; d = dv;
    case ({mr, le})
      2'b10: model[a] = dv;
      2'b11: model = model;
      2'b00: begin model = '0; model[a] = dv; end
      default: model = '0;
    endcase
    @(posedge clk); #1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic dv, input string tag);
    cyc(1'b1, 1'b1, a, 1'b0, "R4 pre-write hold");
    cyc(1'b0, 1'b1, a, dv, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; le_n = 1'b0; mr_n = 1'b1; d = 1'b1;
    model = '0;
    @(posedge clk); #1;
    exp_q.push_back(model);
    tag_q.push_back(tag);
    @(negedge clk);
    rst_n = 1'b1; le_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R1: reset state held for a few cycles
    repeat (2) @(negedge clk);
    checks++;
    if (q !== '0) begin
      errors++;
      $display("FAIL R1: q=%b expected %b", q, 8'h00);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R8: fill all addresses with an alternating pattern
    for (int k = 0; k < NB; k++) wr(3'(k), k[0], "R2 R3 R8 write");
    // R3: overwrite middle cells, neighbours preserved
    wr(3'd3, 1'b0, "R3 keep neighbours");
    wr(3'd4, 1'b1, "R3 keep neighbours");
    wr(3'd0, 1'b1, "R8 lsb select");

    // R4: hold with changing address and data
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1, 3'(k * 3), k[0], "R4 hold");

    // R6 R5: decode with d high across all addresses
    for (int k = 0; k < NB; k++) cyc(1'b0, 1'b0, 3'(k), 1'b1, "R5 R6 decode");
    // R9: hold after decode
    cyc(1'b1, 1'b1, 3'd2, 1'b1, "R9 hold after decode");
    cyc(1'b1, 1'b1, 3'd5, 1'b0, "R9 hold after decode");

    // refill then decode with d low: all zero (R5)
    for (int k = 0; k < NB; k++) wr(3'(k), 1'b1, "R2 refill");
    cyc(1'b0, 1'b0, 3'd6, 1'b0, "R5 decode d low");
    wr(3'd1, 1'b1, "R2 write after decode");
    cyc(1'b0, 1'b0, 3'd7, 1'b1, "R5 decode clears others");

    // R7: clear with nonzero addr and d
    for (int k = 0; k < 4; k++) wr(3'(k * 2), 1'b1, "R2 pre-clear");
    cyc(1'b1, 1'b0, 3'd5, 1'b1, "R7 clear");
    cyc(1'b1, 1'b0, 3'd7, 1'b0, "R7 clear");
    cyc(1'b1, 1'b1, 3'd3, 1'b1, "R9 hold after clear");

    // R1: reset in the middle of a run
    wr(3'd6, 1'b1, "R2 pre-reset");
    wr(3'd2, 1'b1, "R2 pre-reset");
    do_reset("R1 async reset");
    wr(3'd5, 1'b1, "R2 after reset");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule